// File: doc/BRIEF.md
# Five-Digit Sequence Combination Lock

This block watches a stream of keypad entries. It raises an open indication once the digits 1, 2, 3, 4 and 5 have been keyed in that order. Each entry arrives on a bus of one-hot digit lines, one line per decimal digit. An entry is taken only in a cycle where the strobe is high. The block keeps one state for each length of correctly matched prefix, from zero (idle) up to the full five digits. The open output is decoded from the state alone, so it is a Moore output.

A wrong digit usually sends the machine back to idle. Digit 1 is the exception: it always leaves the machine holding a one-digit match, whatever prefix was held before. A user who fumbles can therefore start again at once without first clearing the lock. Reaching the open state does not latch it. The next strobed digit is judged as if the machine were idle.

Top module: `combo_lock_fsm`

## Requirements
- R1: A synchronous reset, active high on `rst`, returns the machine to idle with `open_o` low. This happens even when a strobe carrying the final digit arrives in the same cycle.
- R2: With a one-digit to four-digit prefix held, or when idle, a strobed entry of the next code digit extends the match by one. The code is digit k+1 for position k, and digit d is line d of `key_hot`.
- R3: `open_o` is high only while all five digits are matched. It first rises after the fifth correct digit and never earlier in a sequence.
- R4: A strobed digit 1 (line 1 alone) leaves a one-digit match from any state, including a held one-digit match and the open state.
- R5: A strobed single digit that is neither the next code digit nor digit 1 returns the machine to idle.
- R6: While `key_stb` is low, the state and `open_o` hold whatever `key_hot` carries.
- R7: A strobed entry with zero lines high, or with more than one line high, is a wrong entry and returns the machine to idle. This holds even when line 1 or the expected line is among those high.
- R8: From the open state, any strobed entry leaves it. Digit 1 goes to a one-digit match and anything else goes to idle, so `open_o` falls after that edge.
- R9: `open_o` changes on the clock edge that samples the strobed fifth digit. It is low during the strobe cycle and high right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| key_stb | input | 1 | Marks the cycle in which `key_hot` carries an entry |
| key_hot | input | NUM_KEYS (10) | One-hot digit lines, bit d means digit d |
| open_o | output | 1 | High while the full code is matched |

## Verification
Digit 1 is special: the advance rule and the restart rule can claim the same entry. In idle, digit 1 is both the next code digit and the restart digit. In a held one-digit match, or in the open state, only the restart rule applies. The bench provokes this in three ways: repeated 1s, a 1 dropped into the middle of a four-digit prefix, and a 1 keyed straight after opening. Each case is judged by feeding the remaining digits and checking that `open_o` rises exactly after the fifth. Entries that mix line 1 with another line show that the restart rule needs a clean one-hot entry.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

  typedef int unsigned uint_t;

  // Digit value of code position 0; the code runs upward from here.
  localparam uint_t FIRST_KEY = 1;

  // Digit expected at code position pos.
  function automatic uint_t code_key(input uint_t pos);
    return FIRST_KEY + pos;
  endfunction

endpackage

// File: rtl/combo_key_decode.sv
module combo_key_decode #(
  parameter  int unsigned NUM_KEYS = 10,
  localparam int unsigned IW = $clog2(NUM_KEYS),
  localparam int unsigned CW = $clog2(NUM_KEYS + 1)
) (
  input  logic [NUM_KEYS-1:0] key_hot,
  output logic                key_single,
  output logic [IW-1:0]       key_idx
);

  logic [CW-1:0] hits;
  logic [IW-1:0] idx;

  // Count the raised lines and remember the position of the last one.
  always_comb begin
    hits = '0;
    idx  = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (key_hot[i]) begin
        hits = hits + CW'(1);
        idx  = IW'(i);
      end
    end
  end

  assign key_single = (hits == CW'(1));
  assign key_idx    = idx;

endmodule

// File: rtl/combo_lock_next.sv
module combo_lock_next
  import combo_lock_pkg::*;
#(
  parameter  int unsigned NUM_KEYS = 10,
  parameter  int unsigned CODE_LEN = 5,
  localparam int unsigned IW = $clog2(NUM_KEYS),
  localparam int unsigned SW = $clog2(CODE_LEN + 1)
) (
  input  logic [SW-1:0] match_q,
  input  logic          key_stb,
  input  logic          key_single,
  input  logic [IW-1:0] key_idx,
  output logic [SW-1:0] match_d,
  output logic          adv_w,
  output logic          restart_w,
  output logic          clear_w
);

  localparam logic [SW-1:0] TOP = SW'(CODE_LEN);

  logic below_top;
  logic want_hit;
  logic first_hit;

  assign below_top = (match_q < TOP);
  assign want_hit  = key_single && (uint_t'(key_idx) == code_key(uint_t'(match_q)));
  assign first_hit = key_single && (uint_t'(key_idx) == FIRST_KEY);

  // Priority: advance, then restart on the first digit, then clear.
  assign adv_w     = key_stb && below_top && want_hit;
  assign restart_w = key_stb && !adv_w && first_hit;
  assign clear_w   = key_stb && !adv_w && !restart_w;

  always_comb begin
    if (adv_w)          match_d = match_q + SW'(1);
    else if (restart_w) match_d = SW'(1);
    else if (clear_w)   match_d = '0;
    else                match_d = match_q;
  end

endmodule

// File: rtl/combo_lock_reg.sv
module combo_lock_reg #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] match_d,
  output logic [SW-1:0] match_q
);

  always_ff @(posedge clk) begin
    if (rst) match_q <= '0;
    else     match_q <= match_d;
  end

endmodule

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm #(
  parameter int unsigned NUM_KEYS = 10,
  parameter int unsigned CODE_LEN = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                key_stb,
  input  logic [NUM_KEYS-1:0] key_hot,
  output logic                open_o
);

  localparam int unsigned IW = $clog2(NUM_KEYS);
  localparam int unsigned SW = $clog2(CODE_LEN + 1);

  logic          key_single;
  logic [IW-1:0] key_idx;
  logic [SW-1:0] match_q;
  logic [SW-1:0] match_d;
  logic          adv_w;
  logic          restart_w;
  logic          clear_w;

  combo_key_decode #(.NUM_KEYS(NUM_KEYS)) u_decode (
    .key_hot    (key_hot),
    .key_single (key_single),
    .key_idx    (key_idx)
  );

  combo_lock_next #(.NUM_KEYS(NUM_KEYS), .CODE_LEN(CODE_LEN)) u_next (
    .match_q    (match_q),
    .key_stb    (key_stb),
    .key_single (key_single),
    .key_idx    (key_idx),
    .match_d    (match_d),
    .adv_w      (adv_w),
    .restart_w  (restart_w),
    .clear_w    (clear_w)
  );

  combo_lock_reg #(.SW(SW)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .match_d (match_d),
    .match_q (match_q)
  );

  // Moore output: full prefix held.
  assign open_o = (match_q == SW'(CODE_LEN));

endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
  import combo_lock_pkg::*;
#(
  parameter  int unsigned NUM_KEYS = 10,
  parameter  int unsigned CODE_LEN = 5,
  localparam int unsigned SW = $clog2(CODE_LEN + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                key_stb,
  input logic [NUM_KEYS-1:0] key_hot,
  input logic                open_o,
  input logic [SW-1:0]       match_q,
  input logic                adv_w,
  input logic                restart_w,
  input logic                clear_w
);

  localparam logic [SW-1:0]       TOP  = SW'(CODE_LEN);
  localparam logic [NUM_KEYS-1:0] ONE  = NUM_KEYS'(1);
  localparam logic [NUM_KEYS-1:0] K1   = ONE << FIRST_KEY;
  localparam logic [NUM_KEYS-1:0] KEND = ONE << code_key(CODE_LEN - 1);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (match_q == '0) && !open_o);

  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    key_stb && ($countones(key_hot) == 1) && (match_q < TOP) &&
    (key_hot == (ONE << code_key(uint_t'(match_q))))
    |=> match_q == $past(match_q) + SW'(1));

  a_r3_open_after_advance: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(adv_w));

  a_r4_first_digit: assert property (@(posedge clk) disable iff (rst)
    key_stb && (key_hot == K1) |=> match_q == SW'(1));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !key_stb |=> $stable(match_q) && $stable(open_o));

  a_r7_bad_entry: assert property (@(posedge clk) disable iff (rst)
    key_stb && ($countones(key_hot) != 1) |=> match_q == '0);

  a_r8_leave_open: assert property (@(posedge clk) disable iff (rst)
    open_o && key_stb |=> !open_o);

  a_r9_rise_on_last: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(key_stb && (key_hot == KEND)));

  a_r5_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adv_w, restart_w, clear_w}));

  a_r5_event_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (adv_w || restart_w || clear_w) |-> key_stb);

endmodule

bind combo_lock_fsm combo_lock_chk #(.NUM_KEYS(NUM_KEYS), .CODE_LEN(CODE_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .key_stb   (key_stb),
  .key_hot   (key_hot),
  .open_o    (open_o),
  .match_q   (match_q),
  .adv_w     (adv_w),
  .restart_w (restart_w),
  .clear_w   (clear_w)
);

// File: tb/tb_combo_lock_fsm.sv
`timescale 1ns/1ps
module tb_combo_lock_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_stb = 1'b0;
  logic [9:0] key_hot = '0;
  logic       open_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  combo_lock_fsm dut (
    .clk     (clk),
    .rst     (rst),
    .key_stb (key_stb),
    .key_hot (key_hot),
    .open_o  (open_o)
  );

  // Entry layout: {req[3:0], strobe, expected open after edge, lines[9:0]}.
  // Line d is digit d: 1=002 2=004 3=008 4=010 5=020 7=080 9=200.
  localparam int NV = 48;
  localparam logic [15:0] VEC [NV] = '{
    {4'd2,1'b1,1'b0,10'h002}, {4'd2,1'b1,1'b0,10'h004},   // R2
    {4'd2,1'b1,1'b0,10'h008}, {4'd2,1'b1,1'b0,10'h010},
    {4'd3,1'b1,1'b1,10'h020},                             // R3 opens
    {4'd6,1'b0,1'b1,10'h000}, {4'd6,1'b0,1'b1,10'h080},   // R6 hold
    {4'd8,1'b1,1'b0,10'h002},                             // R8 open -> one
    {4'd4,1'b1,1'b0,10'h002},                             // R4 one -> one
    {4'd2,1'b1,1'b0,10'h004}, {4'd4,1'b1,1'b0,10'h002},   // R4 two -> one
    {4'd2,1'b1,1'b0,10'h004}, {4'd2,1'b1,1'b0,10'h008},
    {4'd2,1'b1,1'b0,10'h010}, {4'd4,1'b1,1'b0,10'h002},   // R4 four -> one
    {4'd4,1'b1,1'b0,10'h004}, {4'd4,1'b1,1'b0,10'h008},
    {4'd4,1'b1,1'b0,10'h010}, {4'd4,1'b1,1'b1,10'h020},
    {4'd8,1'b1,1'b0,10'h200},                             // R8 open -> idle
    {4'd5,1'b1,1'b0,10'h004}, {4'd5,1'b1,1'b0,10'h008},   // R5 idle stays
    {4'd5,1'b1,1'b0,10'h010}, {4'd5,1'b1,1'b0,10'h020},
    {4'd2,1'b1,1'b0,10'h002}, {4'd2,1'b1,1'b0,10'h004},
    {4'd2,1'b1,1'b0,10'h008}, {4'd5,1'b1,1'b0,10'h080},   // R5 wrong 7
    {4'd5,1'b1,1'b0,10'h010}, {4'd5,1'b1,1'b0,10'h020},
    {4'd2,1'b1,1'b0,10'h002}, {4'd2,1'b1,1'b0,10'h004},
    {4'd7,1'b1,1'b0,10'h000},                             // R7 empty entry
    {4'd7,1'b1,1'b0,10'h008}, {4'd7,1'b1,1'b0,10'h010},
    {4'd7,1'b1,1'b0,10'h020},
    {4'd2,1'b1,1'b0,10'h002}, {4'd7,1'b1,1'b0,10'h006},   // R7 lines 1+2
    {4'd7,1'b1,1'b0,10'h004}, {4'd7,1'b1,1'b0,10'h008},
    {4'd7,1'b1,1'b0,10'h010}, {4'd7,1'b1,1'b0,10'h020},
    {4'd2,1'b1,1'b0,10'h002}, {4'd2,1'b1,1'b0,10'h004},
    {4'd2,1'b1,1'b0,10'h008}, {4'd2,1'b1,1'b0,10'h010},
    {4'd6,1'b0,1'b0,10'h020},                             // R6 unstrobed 5
    {4'd6,1'b1,1'b1,10'h020}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s open_o actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic stb, input logic [9:0] hot);
    @(negedge clk);
    key_stb = stb;
    key_hot = hot;
    @(posedge clk);
    #1;
  endtask

  task automatic to_four();
    step(1'b1, 10'h002); step(1'b1, 10'h004);
    step(1'b1, 10'h008); step(1'b1, 10'h010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", open_o, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][9:0]);
      check($sformatf("R%0d vec%0d", VEC[i][15:12], i), open_o, VEC[i][10]);
    end
    step(1'b0, 10'h000);

    // R9: open_o low during the strobe cycle, high after that edge.
    step(1'b1, 10'h200);
    to_four();
    @(negedge clk);
    key_stb = 1'b1;
    key_hot = 10'h020;
    #1;
    check("R9 before edge", open_o, 1'b0);
    @(posedge clk);
    #1;
    check("R9 after edge", open_o, 1'b1);
    step(1'b0, 10'h000);
    check("R9 held", open_o, 1'b1);

    // R7: all lines high, then the last digit must not open.
    step(1'b1, 10'h200);
    to_four();
    step(1'b1, 10'h3FF);
    check("R7 all lines", open_o, 1'b0);
    step(1'b1, 10'h020);
    check("R7 after all lines", open_o, 1'b0);

    // R1: reset with a strobed final digit in the same cycle.
    to_four();
    @(negedge clk);
    rst = 1'b1;
    key_stb = 1'b1;
    key_hot = 10'h020;
    @(posedge clk);
    #1;
    check("R1 reset wins", open_o, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    key_stb = 1'b0;
    step(1'b1, 10'h020);
    check("R1 idle after reset", open_o, 1'b0);
    to_four();
    step(1'b1, 10'h020);
    check("R1 full code after reset", open_o, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule